// File: doc/BRIEF.md
# Load-Reserved Reservation Tracker

This block holds the single reservation that a load-reserved operation creates in a data cache. When a load-reserved is accepted, the block address of its target is stored and a countdown window opens. While the window is open, a coherence probe that names the same cache block is told to hold off, and a store-conditional to that block is allowed to succeed.

To prevent deadlock, the window is bounded. A down-counter is loaded with `LRSC_CYCLES-1` on every load-reserved and decrements once per cycle until it reaches zero. The reservation counts as live only while the counter is above `LRSC_BACKOFF`. Once it drops to that value, probes to the block pass and any late store-conditional fails. Every store-conditional, whether it passes or fails, ends the reservation.

All three event inputs are valid-only strobes. The block accepts an event in every cycle it is presented and applies no back-pressure, so no ready signal exists. Probe and store-conditional results are combinational and answer in the same cycle as their strobe. Addresses are compared on the block address, which is the address with the low 6 bits (64-byte blocks) dropped.

Top module: `lrsc_tracker`

## Requirements
- R1: After reset no reservation exists. `probe_block` and `sc_pass` stay 0 for every address until a load-reserved is accepted.
- R2: A load-reserved accepted in cycle T makes probes to its block see `probe_block`=1 in cycles T+1 through T+(LRSC_CYCLES-1-LRSC_BACKOFF), and 0 from the cycle after that.
- R3: Block match ignores address bits [5:0]. A difference in any bit at position 6 or above gives no match.
- R4: `probe_block` is 0 in any cycle where `probe_valid` is 0.
- R5: `sc_pass` is 1 only when `sc_valid` is 1, the reservation is live, and the store-conditional block matches. The window is the same as for probes in R2.
- R6: Any accepted store-conditional ends the reservation. In following cycles no probe is blocked and no store-conditional passes until a new load-reserved arrives.
- R7: A load-reserved during a live reservation replaces the stored block and restarts the full window.
- R8: When a load-reserved and a store-conditional arrive together, the store-conditional is judged against the old reservation. The new reservation takes effect from the next cycle.
- R9: Once the window has run out, the reservation stays expired for any number of cycles. The counter does not wrap.
- R10: A probe and a store-conditional in the same cycle are both judged against the reservation as it stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_valid | input | 1 | Load-reserved accepted this cycle |
| lr_addr | input | ADDR_W | Load-reserved target address |
| sc_valid | input | 1 | Store-conditional accepted this cycle |
| sc_addr | input | ADDR_W | Store-conditional target address |
| probe_valid | input | 1 | Probe to be checked this cycle |
| probe_addr | input | ADDR_W | Probe target address |
| probe_block | output | 1 | Probe must wait (same cycle) |
| sc_pass | output | 1 | Store-conditional succeeds (same cycle) |

## Verification
Two pairs of events can land in the same cycle. The first pair is a store-conditional with a probe. The bench fires both at a live matching block and expects both to see the reservation, then expects a probe in the next cycle to pass freely. The second pair is a load-reserved with a store-conditional. The bench expects the store-conditional to be judged on the old block, and then expects probes in the next cycle to be blocked on the new block only. Window edges are swept cycle by cycle against the arithmetic bound `LRSC_CYCLES-1-LRSC_BACKOFF`.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  // Command applied to the window counter in one cycle.
  typedef enum logic [1:0] {
    WIN_HOLD  = 2'd0,
    WIN_LOAD  = 2'd1,
    WIN_CLEAR = 2'd2
  } win_cmd_e;

  // Query lanes checked against the stored block.
  localparam int unsigned LANE_PROBE = 0;
  localparam int unsigned LANE_SC    = 1;
  localparam int unsigned NUM_LANES  = 2;

endpackage

// File: rtl/lrsc_window.sv
module lrsc_window
  import lrsc_pkg::*;
#(
  parameter int unsigned LRSC_CYCLES  = 100,
  parameter int unsigned LRSC_BACKOFF = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  win_cmd_e cmd,
  output logic     live
);
  localparam int unsigned CW = (LRSC_CYCLES > 2) ? $clog2(LRSC_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(LRSC_CYCLES - 1);
  localparam logic [CW-1:0] BACK_V = CW'(LRSC_BACKOFF);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case (cmd)
        WIN_LOAD:  cnt_q <= LOAD_V;
        WIN_CLEAR: cnt_q <= '0;
        default:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign live = (cnt_q > BACK_V);
endmodule

// File: rtl/lrsc_tag_reg.sv
module lrsc_tag_reg #(
  parameter int unsigned TAG_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tag_q <= '0;
    else if (load) tag_q <= tag_in;
  end
endmodule

// File: rtl/lrsc_match.sv
module lrsc_match
  import lrsc_pkg::*;
#(
  parameter int unsigned TAG_W = 34
) (
  input  logic                        live,
  input  logic [TAG_W-1:0]            resv_tag,
  input  logic [NUM_LANES-1:0]        q_valid,
  input  logic [NUM_LANES-1:0][TAG_W-1:0] q_tag,
  output logic [NUM_LANES-1:0]        hit
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign hit[g] = q_valid[g] && live && (q_tag[g] == resv_tag);
  end
endmodule

// File: rtl/lrsc_tracker.sv
module lrsc_tracker
  import lrsc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 40,
  parameter int unsigned BLK_OFF      = 6,
  parameter int unsigned LRSC_CYCLES  = 100,
  parameter int unsigned LRSC_BACKOFF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_valid,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_block,
  output logic              sc_pass
);
  localparam int unsigned TAG_W = ADDR_W - BLK_OFF;

  win_cmd_e                          cmd;
  logic                              live;
  logic [TAG_W-1:0]                  resv_tag;
  logic [NUM_LANES-1:0]              q_valid;
  logic [NUM_LANES-1:0][TAG_W-1:0]   q_tag;
  logic [NUM_LANES-1:0]              hit;

  // Load-reserved wins the next state; a concurrent SC is judged on the old one.
  always_comb begin
    if (lr_valid)      cmd = WIN_LOAD;
    else if (sc_valid) cmd = WIN_CLEAR;
    else               cmd = WIN_HOLD;
  end

  lrsc_window #(
    .LRSC_CYCLES (LRSC_CYCLES),
    .LRSC_BACKOFF(LRSC_BACKOFF)
  ) u_win (
    .clk  (clk),
    .rst_n(rst_n),
    .cmd  (cmd),
    .live (live)
  );

  lrsc_tag_reg #(.TAG_W(TAG_W)) u_tag (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (lr_valid),
    .tag_in(lr_addr[ADDR_W-1:BLK_OFF]),
    .tag_q (resv_tag)
  );

  assign q_valid[LANE_PROBE] = probe_valid;
  assign q_tag[LANE_PROBE]   = probe_addr[ADDR_W-1:BLK_OFF];
  assign q_valid[LANE_SC]    = sc_valid;
  assign q_tag[LANE_SC]      = sc_addr[ADDR_W-1:BLK_OFF];

  lrsc_match #(.TAG_W(TAG_W)) u_match (
    .live    (live),
    .resv_tag(resv_tag),
    .q_valid (q_valid),
    .q_tag   (q_tag),
    .hit     (hit)
  );

  assign probe_block = hit[LANE_PROBE];
  assign sc_pass     = hit[LANE_SC];
endmodule

// File: rtl/lrsc_tracker_chk.sv
module lrsc_tracker_chk #(
  parameter int unsigned ADDR_W       = 40,
  parameter int unsigned BLK_OFF      = 6,
  parameter int unsigned LRSC_CYCLES  = 100,
  parameter int unsigned LRSC_BACKOFF = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lr_valid,
  input logic [ADDR_W-1:0] lr_addr,
  input logic              sc_valid,
  input logic [ADDR_W-1:0] sc_addr,
  input logic              probe_valid,
  input logic [ADDR_W-1:0] probe_addr,
  input logic              probe_block,
  input logic              sc_pass
);
  localparam int unsigned WIN = LRSC_CYCLES - 1 - LRSC_BACKOFF;

  // Cycles elapsed since the last load-reserved, saturating; armed=0 after SC or reset.
  logic        armed;
  int unsigned age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      age   <= 0;
    end else if (lr_valid) begin
      armed <= 1'b1;
      age   <= 0;
    end else if (sc_valid) begin
      armed <= 1'b0;
    end else if (age < LRSC_CYCLES) begin
      age <= age + 1;
    end
  end

  a_r4_no_probe_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_valid |-> !probe_block);

  a_r5_pass_needs_sc: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> sc_valid);

  a_r2_block_after_lr: assert property (@(posedge clk) disable iff (!rst_n)
    lr_valid |=> ((probe_valid &&
                   probe_addr[ADDR_W-1:BLK_OFF] == $past(lr_addr[ADDR_W-1:BLK_OFF]))
                  -> probe_block));

  a_r6_sc_ends_resv: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !lr_valid) |=> (!probe_block && !sc_pass));

  a_r9_block_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    probe_block |-> (armed && age < WIN));

  a_r5_pass_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> (armed && age < WIN));
endmodule

bind lrsc_tracker lrsc_tracker_chk #(
  .ADDR_W      (ADDR_W),
  .BLK_OFF     (BLK_OFF),
  .LRSC_CYCLES (LRSC_CYCLES),
  .LRSC_BACKOFF(LRSC_BACKOFF)
) u_chk (.*);

// File: tb/sim_lrsc_tracker.sv
`timescale 1ns/1ps
module sim_lrsc_tracker;
  localparam int AW  = 40;
  localparam int CYC = 12;
  localparam int BO  = 3;
  localparam int WIN = CYC - 1 - BO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lr_valid = 1'b0, sc_valid = 1'b0, probe_valid = 1'b0;
  logic [AW-1:0] lr_addr = '0, sc_addr = '0, probe_addr = '0;
  logic probe_block, sc_pass;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lrsc_tracker #(.ADDR_W(AW), .BLK_OFF(6), .LRSC_CYCLES(CYC), .LRSC_BACKOFF(BO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr),
    .probe_block(probe_block), .sc_pass(sc_pass)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Advance one cycle; all strobes drop after the edge.
  task automatic tick();
    @(negedge clk);
    lr_valid = 0; sc_valid = 0; probe_valid = 0;
  endtask

  task automatic do_lr(logic [AW-1:0] a);
    lr_valid = 1; lr_addr = a; tick();
  endtask

  task automatic do_clear();
    sc_valid = 1; sc_addr = '0; tick();
  endtask

  task automatic probe_chk(string req, logic [AW-1:0] a, logic exp);
    probe_valid = 1; probe_addr = a; #1; chk(req, probe_block, exp); tick();
  endtask

  localparam logic [AW-1:0] A = 40'h12_3456_7880;
  localparam logic [AW-1:0] B = 40'h00_0abc_d140;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    probe_valid = 1; probe_addr = '0; sc_valid = 1; sc_addr = '0; #1;
    chk("R1 probe", probe_block, 1'b0);
    chk("R1 sc", sc_pass, 1'b0);
    tick();
    rst_n = 1;
    tick();
    probe_chk("R1 after reset", A, 1'b0);

    // R2 / R9: probe window sweep
    for (int d = 0; d < CYC + 2; d++) begin
      do_lr(A);
      repeat (d) tick();
      probe_chk("R2/R9 probe window", A, (d < WIN));
      do_clear();
    end
    // R5: SC window sweep
    for (int d = 0; d < CYC + 2; d++) begin
      do_lr(A);
      repeat (d) tick();
      sc_valid = 1; sc_addr = A; #1;
      chk("R5 sc window", sc_pass, (d < WIN));
      tick();
    end
    // R3: low offsets match
    for (int o = 0; o < 64; o++) begin
      do_lr(A);
      probe_chk("R3 offset", A ^ AW'(o), 1'b1);
      do_clear();
    end
    // R3: any bit at 6 or above breaks match
    for (int b = 6; b < AW; b++) begin
      do_lr(A);
      probe_chk("R3 tag bit", A ^ (AW'(1) << b), 1'b0);
      sc_valid = 1; sc_addr = A ^ (AW'(1) << b); #1;
      chk("R5 sc mismatch", sc_pass, 1'b0);
      tick();
    end
    // R4: no valid, no block
    do_lr(A);
    probe_addr = A; #1;
    chk("R4 idle probe", probe_block, 1'b0);
    tick();
    // R6: SC clears
    sc_valid = 1; sc_addr = B; #1;
    chk("R6 sc mismatch fails", sc_pass, 1'b0);
    tick();
    probe_chk("R6 cleared probe", A, 1'b0);
    sc_valid = 1; sc_addr = A; #1;
    chk("R6 cleared sc", sc_pass, 1'b0);
    tick();
    // R7: re-LR replaces and restarts
    do_lr(A);
    repeat (5) tick();
    do_lr(B);
    repeat (6) tick();
    probe_chk("R7 new block held", B, 1'b1);
    probe_chk("R7 old block freed", A, 1'b0);
    do_clear();
    // R8: LR and SC together
    do_lr(A);
    lr_valid = 1; lr_addr = B; sc_valid = 1; sc_addr = A; #1;
    chk("R8 sc on old resv", sc_pass, 1'b1);
    tick();
    probe_chk("R8 new resv live", B, 1'b1);
    probe_chk("R8 old resv gone", A, 1'b0);
    do_clear();
    lr_valid = 1; lr_addr = B; sc_valid = 1; sc_addr = B; #1;
    chk("R8 no prior resv", sc_pass, 1'b0);
    tick();
    probe_chk("R8 lr took effect", B, 1'b1);
    do_clear();
    // R10: probe and SC together
    do_lr(A);
    probe_valid = 1; probe_addr = A; sc_valid = 1; sc_addr = A; #1;
    chk("R10 probe sees resv", probe_block, 1'b1);
    chk("R10 sc passes", sc_pass, 1'b1);
    tick();
    probe_chk("R10 probe after sc", A, 1'b0);
    // R9: long idle, no wrap
    do_lr(A);
    for (int k = 0; k < 4 * CYC; k++) begin
      probe_valid = 1; probe_addr = A; #1;
      chk("R9 long idle", probe_block, (k < WIN));
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule